// File: doc/BRIEF.md
# Golay (23,12) Check-Bit Generator

This block turns a 12-bit message into the 11 check bits of the perfect binary Golay code and returns the 23-bit systematic codeword, with the message in the upper bits and the check field in the lower bits. The check field is the remainder of the message, padded with 11 zero positions, divided by the generator polynomial x^11+x^10+x^6+x^5+x^4+x^2+1 (0xC75) in modulo-2 arithmetic.

The division runs over several cycles and does not use a one-bit-per-clock shift register. In each cycle the block does three things. It XORs the generator into a 12-bit working residue if the residue's top bit is set. A priority encoder then counts the leading zeros. The residue is then rotated left past those zeros in one step. A countdown register starts at 11 and loses the rotation amount each cycle. The rotation is clamped to that countdown, so the residue never passes the padded positions. When the countdown reaches zero, a last reduction gives the remainder. A message enters on a valid/ready input. The result leaves on a valid/ready output that holds it under back-pressure. The input accepts only when the block is idle, or when the held result is being taken in the same cycle.

Top module: `golay_chk_gen`

## Requirements
- R1: While rst_n is low at a rising edge, the block returns to idle. After that edge out_valid is 0 and in_ready is 1.
- R2: out_chk equals the remainder of (message · x^11) modulo x^11+x^10+x^6+x^5+x^4+x^2+1. Message bit 11 is the highest-degree coefficient, and out_chk bit 10 is the x^10 coefficient.
- R3: out_code carries the accepted message in bits 22:11 and the check field in bits 10:0. out_chk equals out_code[10:0].
- R4: The all-zero message yields all-zero check bits after a single division cycle. out_valid rises after the second rising edge following the accepting edge.
- R5: For any message, out_valid rises no later than after the 12th rising edge following the accepting edge.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_code and out_chk stay unchanged at the next edge.
- R7: in_ready is 0 from acceptance until the result is valid. A message presented in that window is not taken and does not disturb the result in flight.
- R8: When out_valid and out_ready are both 1, in_ready is 1. A message offered in that cycle is accepted on the same edge that hands off the result, and its division starts at once.
- R9: Exactly one result is produced per accepted message, and results come out in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A message is offered |
| in_ready | output | 1 | The block takes the offered message at this edge |
| in_msg | input | 12 | Message bits |
| out_valid | output | 1 | out_chk and out_code hold a result |
| out_ready | input | 1 | The consumer takes the result at this edge |
| out_chk | output | 11 | Check bits |
| out_code | output | 23 | Systematic codeword {message, check bits} |

## Verification
Two events can land on the same edge: the handoff of a finished codeword and the acceptance of the next message. With out_ready held high and messages queued back to back, every result handoff coincides with a new load of the residue and countdown. The scoreboard then confirms that the departing codeword and the next one are both exact, and it counts how often the overlap happened. A second phase inserts periodic back-pressure to separate the two events, and checks that a held result stays frozen while a waiting message is refused.

// File: rtl/golay_pkg.sv
package golay_pkg;
  localparam int GP_MSG_W  = 12;
  localparam int GP_CHK_W  = 11;
  localparam int GP_CODE_W = GP_MSG_W + GP_CHK_W;
  localparam logic [GP_MSG_W-1:0] GP_GEN = 12'hC75;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_HOLD = 2'd2
  } gdiv_state_e;

  // Straight long division over the padded dividend, used by the checker.
  function automatic logic [GP_CHK_W-1:0] golay_ref_rem(input logic [GP_MSG_W-1:0] m);
    logic [GP_CODE_W-1:0] d;
    d = {m, {GP_CHK_W{1'b0}}};
    for (int b = GP_CODE_W - 1; b >= GP_CHK_W; b--) begin
      if (d[b]) d = d ^ (GP_CODE_W'(GP_GEN) << (b - GP_CHK_W));
    end
    return d[GP_CHK_W-1:0];
  endfunction
endpackage

// File: rtl/lz_prio_enc.sv
// Counts zeros above the most significant set bit; an all-zero input reports W.
module lz_prio_enc #(
  parameter int W  = 12,
  parameter int OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [OW-1:0] lz_o
);
  always_comb begin
    lz_o = OW'(W);
    // ascending scan: the highest set bit is written last and wins
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) lz_o = OW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/rotl_var.sv
// Logarithmic left rotator: stage k rotates by 2^k when amount bit k is set.
module rotl_var #(
  parameter int W  = 12,
  parameter int SW = $clog2(W + 1)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stg [SW+1];

  assign stg[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int RK = (1 << k) % W;
    if (RK == 0) begin : g_pass
      assign stg[k+1] = stg[k];
    end else begin : g_rot
      assign stg[k+1] = amt_i[k] ? {stg[k][W-1-RK:0], stg[k][W-1:W-RK]} : stg[k];
    end
  end

  assign data_o = stg[SW];
endmodule

// File: rtl/golay_div_step.sv
// One division cycle: conditional generator XOR, leading-zero count,
// clamp to the remaining padded positions, rotate, and decrement the countdown.
module golay_div_step #(
  parameter int MSG_W = 12,
  parameter int CHK_W = 11,
  parameter logic [MSG_W-1:0] GEN = 12'hC75,
  parameter int CNT_W = $clog2(CHK_W + 1),
  parameter int SH_W  = $clog2(MSG_W + 1)
) (
  input  logic [MSG_W-1:0] res_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [MSG_W-1:0] res_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o
);
  logic [MSG_W-1:0] xored;
  logic [SH_W-1:0]  lz;
  logic [SH_W-1:0]  cnt_ext;
  logic [SH_W-1:0]  shamt;

  // modulo-2 subtraction is a plain XOR; it clears the top bit when set
  assign xored = res_i[MSG_W-1] ? (res_i ^ GEN) : res_i;

  lz_prio_enc #(.W(MSG_W), .OW(SH_W)) u_lz (
    .vec_i(xored),
    .lz_o (lz)
  );

  assign cnt_ext = SH_W'(cnt_i);
  assign shamt   = (lz > cnt_ext) ? cnt_ext : lz;
  assign adv_o   = |shamt;

  // bits rotated around are the leading zeros, so the rotation equals a shift
  rotl_var #(.W(MSG_W), .SW(SH_W)) u_rot (
    .data_i(xored),
    .amt_i (shamt),
    .data_o(res_o)
  );

  assign cnt_o = adv_o ? (cnt_i - CNT_W'(shamt)) : cnt_i;
endmodule

// File: rtl/golay_chk_gen.sv
module golay_chk_gen
  import golay_pkg::*;
#(
  parameter int MSG_W = GP_MSG_W,
  parameter int CHK_W = GP_CHK_W,
  parameter logic [MSG_W-1:0] GEN = GP_GEN
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [MSG_W-1:0]         in_msg,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [CHK_W-1:0]         out_chk,
  output logic [MSG_W+CHK_W-1:0]   out_code
);
  localparam int CODE_W = MSG_W + CHK_W;
  localparam int CNT_W  = $clog2(CHK_W + 1);
  localparam int SH_W   = $clog2(MSG_W + 1);

  gdiv_state_e      state_q;
  logic [MSG_W-1:0] res_q, msg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CODE_W-1:0] code_q;

  logic             accept, take;
  logic [MSG_W-1:0] step_res;
  logic [CNT_W-1:0] step_cnt;
  logic             step_adv;
  logic [CHK_W-1:0] fin_chk;
  logic [MSG_W-1:0] res_d;
  logic [CNT_W-1:0] cnt_d;

  assign out_valid = (state_q == ST_HOLD);
  assign in_ready  = (state_q == ST_IDLE) || (out_valid && out_ready);
  assign accept    = in_valid && in_ready;
  assign take      = out_valid && out_ready;

  golay_div_step #(
    .MSG_W(MSG_W), .CHK_W(CHK_W), .GEN(GEN), .CNT_W(CNT_W), .SH_W(SH_W)
  ) u_step (
    .res_i(res_q),
    .cnt_i(cnt_q),
    .res_o(step_res),
    .cnt_o(step_cnt),
    .adv_o(step_adv)
  );

  // closing reduction once every padded position has been consumed
  assign fin_chk = res_q[CHK_W-1:0] ^ (res_q[MSG_W-1] ? GEN[CHK_W-1:0] : '0);

  // 2:1 selection: a fresh message on load, otherwise the rotated residue
  assign res_d = accept ? in_msg : step_res;
  assign cnt_d = accept ? CNT_W'(CHK_W) : step_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      res_q   <= '0;
      cnt_q   <= '0;
      msg_q   <= '0;
      code_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_DIV;
            res_q   <= res_d;
            cnt_q   <= cnt_d;
            msg_q   <= in_msg;
          end
        end
        ST_DIV: begin
          if (cnt_q == '0) begin
            code_q  <= {msg_q, fin_chk};
            state_q <= ST_HOLD;
          end else if (step_adv) begin
            res_q <= res_d;
            cnt_q <= cnt_d;
          end
        end
        ST_HOLD: begin
          if (take) begin
            if (accept) begin
              state_q <= ST_DIV;
              res_q   <= res_d;
              cnt_q   <= cnt_d;
              msg_q   <= in_msg;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_code = code_q;
  assign out_chk  = code_q[CHK_W-1:0];
endmodule

// File: rtl/golay_chk_sva.sv
module golay_chk_sva
  import golay_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [GP_MSG_W-1:0]  in_msg,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [GP_CHK_W-1:0]  out_chk,
  input logic [GP_CODE_W-1:0] out_code
);
  localparam int LAT_MAX = GP_CHK_W + 1;
  localparam int LAT_W   = $clog2(LAT_MAX + 2) + 1;

  logic [GP_MSG_W-1:0] held_msg;
  logic [LAT_W-1:0]    lat_q;
  logic                busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_msg <= '0;
      lat_q    <= '0;
      busy_q   <= 1'b0;
    end else if (in_valid && in_ready) begin
      held_msg <= in_msg;
      lat_q    <= LAT_W'(1);
      busy_q   <= 1'b1;
    end else if (out_valid) begin
      lat_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  p_rst_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready));

  p_rem_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chk == golay_ref_rem(out_code[GP_CODE_W-1:GP_CHK_W])));

  p_msg_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && busy_q) |-> (out_code[GP_CODE_W-1:GP_CHK_W] == held_msg));

  p_zero_msg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_code[GP_CODE_W-1:GP_CHK_W] == '0) |-> (out_chk == '0));

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !out_valid) |-> (lat_q <= LAT_W'(LAT_MAX)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_chk)));

  p_busy_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !out_valid) |-> !in_ready);

  p_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready);
endmodule

bind golay_chk_gen golay_chk_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_msg   (in_msg),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_chk  (out_chk),
  .out_code (out_code)
);

// File: tb/tb_golay_chk_gen.sv
module tb_golay_chk_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_msg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [10:0] out_chk;
  logic [22:0] out_code;

  golay_chk_gen dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_msg(in_msg),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_chk(out_chk), .out_code(out_code)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [22:0] code;
    int          acc;
    bit          latchk;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, fails = 0;
  int   cycn = 0;
  int   pushed = 0, popped = 0, overlaps = 0;
  bit   stall_mode = 1'b0;
  bit   stall_seen = 1'b0;
  logic [22:0] stall_code;

  // CRC-style serial remainder: feedback = incoming bit XOR register top
  function automatic logic [10:0] ref_chk(input logic [11:0] m);
    logic [10:0] r = '0;
    logic fb;
    for (int i = 11; i >= 0; i--) begin
      fb = m[i] ^ r[10];
      r  = {r[9:0], 1'b0};
      if (fb) r = r ^ 11'h475;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cycn++;
    out_ready = stall_mode ? ((cycn % 5) > 1) : 1'b1;
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      // R6: a result held under back-pressure must not move
      if (stall_seen) begin
        chk(out_valid === 1'b1 && out_code === stall_code, "R6", {9'd0, out_code}, {9'd0, stall_code});
        stall_seen = 1'b0;
      end
      if (out_valid && !out_ready) begin
        stall_seen = 1'b1;
        stall_code = out_code;
      end
      if (out_valid && out_ready) begin
        if (in_valid && in_ready) overlaps++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          popped++;
          chk(out_code === e.code, "R2/R3 codeword", {9'd0, out_code}, {9'd0, e.code});
          chk(out_chk === out_code[10:0], "R3 chk field", {21'd0, out_chk}, {21'd0, out_code[10:0]});
          if (e.latchk) begin
            if (e.code[22:11] == '0)
              chk((cycn - e.acc) == 3, "R4 latency", cycn - e.acc, 3);
            else
              chk((cycn - e.acc) <= 13, "R5 latency", cycn - e.acc, 13);
          end
        end
      end
    end
  end

  task automatic send(input logic [11:0] m, input bit lc);
    bit got = 1'b0;
    while (!got) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_msg   = m;
      #1;
      if (in_ready) begin
        exp_q.push_back('{code: {m, ref_chk(m)}, acc: cycn, latchk: lc});
        pushed++;
        got = 1'b1;
      end
    end
  endtask

  task automatic drop();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R1 out_valid", {31'd0, out_valid}, 0);
    chk(in_ready === 1'b1, "R1 in_ready", {31'd0, in_ready}, 1);
    rst_n = 1'b1;

    // R4: zero message, exact two-edge latency, zero check bits
    send(12'h000, 1'b1);
    drop();
    drain();

    // R7: offer B while A is in flight; it may only be taken with A's handoff
    send(12'hFFF, 1'b1);
    begin
      bit got = 1'b0;
      while (!got) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_msg   = 12'h5A3;
        #1;
        if (in_ready) begin
          chk(out_valid === 1'b1, "R7 taken early", {31'd0, out_valid}, 1);
          exp_q.push_back('{code: {12'h5A3, ref_chk(12'h5A3)}, acc: cycn, latchk: 1'b1});
          pushed++;
          got = 1'b1;
        end
      end
    end
    drop();
    drain();

    // R2, R5, R8: every message back to back, consumer always ready
    for (int i = 0; i < 4096; i++) send(12'(i), 1'b1);
    drop();
    drain();

    // R6, R9: periodic back-pressure
    stall_mode = 1'b1;
    for (int i = 0; i < 400; i++) send(12'((i * 37 + 5) % 4096), 1'b0);
    drop();
    drain();
    stall_mode = 1'b0;
    repeat (3) @(negedge clk);

    chk(overlaps > 0, "R8 overlap count", overlaps, 1);
    chk(pushed == popped && exp_q.size() == 0, "R9 result count", popped, pushed);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cycn);
    report();
  end
endmodule